// File: doc/BRIEF.md
# Speculative Load Violation Detector

This block watches loads that returned data while a memory-ordering rule still held them back. Each load-queue slot has one tracking entry. When a load in a slot completes before its ordering constraints are met, the entry stores the cache-line address of that load and marks it as speculative. The entry stays speculative until the slot's constraints-satisfied level goes high.

While an entry is speculative, the entry compares every coherence event against its stored line. A coherence event is either an invalidation caused by another processor or a local line replacement. On a match, the entry raises a sticky soft-exception flag. That flag means the load must reissue and every younger instruction must be flushed. A store-address conflict from the load-store queue uses the same flag and squash path. The squash request always names the oldest flagged slot, and slot index 0 is the oldest. A flush input clears the named slot and every younger slot.

Top module: `spec_load_guard`

## Requirements
- R1: After reset, no entry is tracked, `soft_exc` is all zero and `squash_vld` is low.
- R2: When `cmp_vld` is high and bit `cmp_idx` of `rel_mask` is low, that entry starts tracking line `cmp_addr[ADDR_W-1:6]`. A completion whose `rel_mask` bit is high at that edge is not tracked.
- R3: A coherence event (`coh_vld`) whose address bits above bit 5 equal a tracked line sets that entry's `soft_exc` bit at the next edge. The low 6 offset bits are ignored, and an event to another line changes nothing.
- R4: An entry whose `rel_mask` bit was high at any edge is no longer tracked. Later events to its line do not flag it.
- R5: A coherence event that arrives in the same cycle that the entry's `rel_mask` bit is high does not flag that entry.
- R6: A `soft_exc` bit stays set until a flush clears it. Once flagged, an entry is no longer tracked, and completions and `rel_mask` leave the bit unchanged.
- R7: `sac_vld` sets `soft_exc[sac_idx]` at the next edge. This is the store-address conflict input, and it shares the squash path.
- R8: `squash_vld` is high exactly when any `soft_exc` bit is set. `squash_idx` is then the lowest set index, and index 0 is the oldest.
- R9: `flush_vld` clears both tracking and `soft_exc` for every index greater than or equal to `flush_idx` and leaves lower indices untouched. For the cleared slots, the flush overrides any event, completion or conflict in the same cycle.
- R10: A coherence event is compared only against lines stored before that edge. A load completing in the same cycle as an event to its line is not flagged by that event.
- R11: One coherence event flags every tracked entry that holds its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_vld | input | 1 | Load completion strobe |
| cmp_idx | input | IW | Slot of the completing load |
| cmp_addr | input | ADDR_W | Byte address of the completing load |
| rel_mask | input | ENTRIES | Per-slot constraints-satisfied level |
| coh_vld | input | 1 | Coherence event strobe (invalidation or replacement) |
| coh_addr | input | ADDR_W | Address of the coherence event |
| sac_vld | input | 1 | Store-address conflict strobe |
| sac_idx | input | IW | Slot hit by the store-address conflict |
| flush_vld | input | 1 | Flush strobe |
| flush_idx | input | IW | Oldest slot cleared by the flush |
| soft_exc | output | ENTRIES | Per-slot soft-exception flags |
| squash_vld | output | 1 | Squash request |
| squash_idx | output | IW | Oldest flagged slot |

## Verification
Four functions can act on the same slot in the same cycle: the snoop match, the release of a slot's constraints, a completion, and the flush. The bench sets up each pair by placing both strobes on one input edge. A release together with a matching event is judged correct when no flag appears afterwards, and a later event shows that the entry is no longer tracked. A completion together with an event to its line is judged correct when no flag appears in that cycle but the next event does flag the entry. A flush together with an event is judged correct when the slots at or above the flush index stay clear and the older slots are still flagged.

// File: rtl/slg_pkg.sv
package slg_pkg;

  // Index of the lowest set bit of a vector of up to 64 bits; 0 when empty.
  function automatic logic [5:0] first_set(input logic [63:0] v);
    logic [5:0] r;
    r = '0;
    for (int k = 63; k >= 0; k--) begin
      if (v[k]) r = 6'(k);
    end
    return r;
  endfunction

  // True when two addresses fall into the same cache line.
  function automatic logic same_line(input logic [63:0] a, input logic [63:0] b,
                                     input int ofs);
    return (a >> ofs) == (b >> ofs);
  endfunction

endpackage

// File: rtl/slg_entry.sv
module slg_entry #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_here,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic              rel,
  input  logic              coh_vld,
  input  logic [ADDR_W-1:0] coh_addr,
  input  logic              sac_here,
  input  logic              kill,
  output logic              spec,
  output logic              flag,
  output logic              hit
);
  import slg_pkg::*;

  logic              spec_q, flag_q;
  logic [ADDR_W-1:0] addr_q;

  assign hit  = spec_q && coh_vld && !rel &&
                same_line(64'(addr_q), 64'(coh_addr), LINE_OFS);
  assign spec = spec_q;
  assign flag = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spec_q <= 1'b0;
      flag_q <= 1'b0;
      addr_q <= '0;
    end else if (kill) begin
      spec_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (hit || sac_here) begin
        flag_q <= 1'b1;
        spec_q <= 1'b0;
      end else if (cmp_here && !flag_q && !rel) begin
        spec_q <= 1'b1;
        addr_q <= cmp_addr;
      end else if (rel) begin
        spec_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/slg_oldest.sv
module slg_oldest #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] flags,
  output logic               any,
  output logic [IW-1:0]      idx
);
  import slg_pkg::*;

  logic [5:0] pick;

  assign pick = first_set(64'(flags));
  assign any  = |flags;
  assign idx  = IW'(pick);

endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard #(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_vld,
  input  logic [IW-1:0]      cmp_idx,
  input  logic [ADDR_W-1:0]  cmp_addr,
  input  logic [ENTRIES-1:0] rel_mask,
  input  logic               coh_vld,
  input  logic [ADDR_W-1:0]  coh_addr,
  input  logic               sac_vld,
  input  logic [IW-1:0]      sac_idx,
  input  logic               flush_vld,
  input  logic [IW-1:0]      flush_idx,
  output logic [ENTRIES-1:0] soft_exc,
  output logic               squash_vld,
  output logic [IW-1:0]      squash_idx
);

  // Named per-entry events for the checker
  logic [ENTRIES-1:0] spec_w;
  logic [ENTRIES-1:0] hit_w;
  logic [ENTRIES-1:0] kill_w;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic cmp_here, sac_here;
    assign cmp_here  = cmp_vld && (cmp_idx == IW'(g));
    assign sac_here  = sac_vld && (sac_idx == IW'(g));
    assign kill_w[g] = flush_vld && (IW'(g) >= flush_idx);

    slg_entry #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) i_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_here (cmp_here),
      .cmp_addr (cmp_addr),
      .rel      (rel_mask[g]),
      .coh_vld  (coh_vld),
      .coh_addr (coh_addr),
      .sac_here (sac_here),
      .kill     (kill_w[g]),
      .spec     (spec_w[g]),
      .flag     (soft_exc[g]),
      .hit      (hit_w[g])
    );
  end

  slg_oldest #(.ENTRIES(ENTRIES)) i_old (
    .flags (soft_exc),
    .any   (squash_vld),
    .idx   (squash_idx)
  );

endmodule

// File: rtl/slg_checker.sv
module slg_checker #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ENTRIES-1:0] rel_mask,
  input logic               sac_vld,
  input logic [IW-1:0]      sac_idx,
  input logic [ENTRIES-1:0] soft_exc,
  input logic               squash_vld,
  input logic [IW-1:0]      squash_idx,
  input logic [ENTRIES-1:0] spec_w,
  input logic [ENTRIES-1:0] hit_w,
  input logic [ENTRIES-1:0] kill_w
);

  logic [ENTRIES-1:0] below;
  assign below = (ENTRIES'(1) << squash_idx) - ENTRIES'(1);

  p_squash_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_vld == (|soft_exc));
  p_squash_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_vld |-> (soft_exc[squash_idx] && ((soft_exc & below) == '0)));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    p_hit_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w[g] && !kill_w[g] |=> soft_exc[g]);
    p_rel_untracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rel_mask[g] |=> !spec_w[g]);
    p_rel_noflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rel_mask[g] && !soft_exc[g] && !(sac_vld && sac_idx == IW'(g)) |=> !soft_exc[g]);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_exc[g] && !kill_w[g] |=> soft_exc[g]);
    p_flag_untracked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(soft_exc[g] && spec_w[g]));
    p_sac_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sac_vld && sac_idx == IW'(g) && !kill_w[g] |=> soft_exc[g]);
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      kill_w[g] |=> !soft_exc[g] && !spec_w[g]);
  end

endmodule

bind spec_load_guard slg_checker #(.ENTRIES(ENTRIES)) i_slg_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rel_mask   (rel_mask),
  .sac_vld    (sac_vld),
  .sac_idx    (sac_idx),
  .soft_exc   (soft_exc),
  .squash_vld (squash_vld),
  .squash_idx (squash_idx),
  .spec_w     (spec_w),
  .hit_w      (hit_w),
  .kill_w     (kill_w)
);

// File: tb/test_spec_load_guard.sv
module test_spec_load_guard;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_vld = 1'b0;
  logic [IW-1:0] cmp_idx = '0;
  logic [AW-1:0] cmp_addr = '0;
  logic [N-1:0]  rel_mask = '0;
  logic          coh_vld = 1'b0;
  logic [AW-1:0] coh_addr = '0;
  logic          sac_vld = 1'b0;
  logic [IW-1:0] sac_idx = '0;
  logic          flush_vld = 1'b0;
  logic [IW-1:0] flush_idx = '0;
  logic [N-1:0]  soft_exc;
  logic          squash_vld;
  logic [IW-1:0] squash_idx;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_load_guard #(.ENTRIES(N), .ADDR_W(AW), .LINE_OFS(6)) i_spec_load_guard (
    .clk(clk), .rst_n(rst_n), .cmp_vld(cmp_vld), .cmp_idx(cmp_idx),
    .cmp_addr(cmp_addr), .rel_mask(rel_mask), .coh_vld(coh_vld),
    .coh_addr(coh_addr), .sac_vld(sac_vld), .sac_idx(sac_idx),
    .flush_vld(flush_vld), .flush_idx(flush_idx), .soft_exc(soft_exc),
    .squash_vld(squash_vld), .squash_idx(squash_idx));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Inputs set just after a falling edge; the rising edge samples them;
  // the next falling edge is where results are read. Strobes then drop.
  task automatic tick();
    @(negedge clk);
    cmp_vld = 1'b0; coh_vld = 1'b0; sac_vld = 1'b0; flush_vld = 1'b0;
  endtask

  task automatic complete(input int idx, input logic [AW-1:0] a);
    cmp_vld = 1'b1; cmp_idx = IW'(idx); cmp_addr = a; tick();
  endtask

  task automatic snoop(input logic [AW-1:0] a);
    coh_vld = 1'b1; coh_addr = a; tick();
  endtask

  task automatic flush_from(input int idx);
    flush_vld = 1'b1; flush_idx = IW'(idx); tick();
  endtask

  task automatic t_reset();
    chk("R1 flags", 32'(soft_exc), 0);
    chk("R1 squash", 32'(squash_vld), 0);
    snoop(32'h0000_0000);
    chk("R1 nothing tracked", 32'(soft_exc), 0);
  endtask

  task automatic t_basic();
    complete(2, 32'h1000_0040);
    snoop(32'h1000_0080);
    chk("R3 other line ignored", 32'(soft_exc), 0);
    snoop(32'h1000_0078);
    chk("R2 R3 offset ignored, flag", 32'(soft_exc), 32'h04);
    chk("R8 squash valid", 32'(squash_vld), 1);
    chk("R8 squash index", 32'(squash_idx), 2);
    flush_from(0);
    chk("R9 full flush", 32'(soft_exc), 0);
  endtask

  task automatic t_multi();
    complete(1, 32'h2000_0100);
    complete(5, 32'h2000_0120);
    snoop(32'h2000_0100);
    chk("R11 both flagged", 32'(soft_exc), 32'h22);
    chk("R8 oldest index", 32'(squash_idx), 1);
    flush_from(3);
    chk("R9 partial flush", 32'(soft_exc), 32'h02);
    chk("R8 after flush", 32'(squash_idx), 1);
    flush_from(0);
  endtask

  task automatic t_release();
    complete(3, 32'h3000_0000);
    rel_mask[3] = 1'b1; tick();
    rel_mask[3] = 1'b0;
    snoop(32'h3000_0000);
    chk("R4 released not flagged", 32'(soft_exc), 0);
    rel_mask[4] = 1'b1; complete(4, 32'h3100_0000);
    rel_mask[4] = 1'b0;
    snoop(32'h3100_0000);
    chk("R2 satisfied at completion", 32'(soft_exc), 0);
  endtask

  task automatic t_same_cycle_release();
    complete(6, 32'h4000_0000);
    rel_mask[6] = 1'b1; snoop(32'h4000_0000);
    rel_mask[6] = 1'b0;
    chk("R5 release wins", 32'(soft_exc), 0);
    snoop(32'h4000_0000);
    chk("R5 R4 untracked afterwards", 32'(soft_exc), 0);
  endtask

  task automatic t_same_cycle_complete();
    cmp_vld = 1'b1; cmp_idx = 3'd7; cmp_addr = 32'h5000_0000;
    snoop(32'h5000_0010);
    chk("R10 same-cycle completion", 32'(soft_exc), 0);
    snoop(32'h5000_0020);
    chk("R10 later event flags", 32'(soft_exc), 32'h80);
    rel_mask[7] = 1'b1; complete(7, 32'h5100_0000);
    rel_mask[7] = 1'b0;
    chk("R6 sticky", 32'(soft_exc), 32'h80);
    snoop(32'h5100_0000);
    chk("R6 flagged not retracked", 32'(soft_exc), 32'h80);
    flush_from(7);
    chk("R9 flush top", 32'(soft_exc), 0);
  endtask

  task automatic t_store_conflict();
    sac_vld = 1'b1; sac_idx = 3'd4; tick();
    chk("R7 conflict flag", 32'(soft_exc), 32'h10);
    chk("R7 squash index", 32'(squash_idx), 4);
    complete(0, 32'h6000_0000);
    snoop(32'h6000_003F);
    chk("R8 oldest wins", 32'(squash_idx), 0);
    chk("R7 R3 combined", 32'(soft_exc), 32'h11);
    flush_from(0);
    chk("R8 squash drops", 32'(squash_vld), 0);
  endtask

  task automatic t_flush_priority();
    complete(1, 32'h7000_0000);
    complete(2, 32'h7000_0000);
    flush_vld = 1'b1; flush_idx = 3'd2; snoop(32'h7000_0000);
    chk("R9 flush over event", 32'(soft_exc), 32'h02);
    snoop(32'h7000_0000);
    chk("R9 flushed untracked", 32'(soft_exc), 32'h02);
    flush_from(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_multi();
    t_release();
    t_same_cycle_release();
    t_same_cycle_complete();
    t_store_conflict();
    t_flush_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule